// File: doc/BRIEF.md
# Snooping Five-State Coherence Controller for a Private Cache

This block keeps the coherence state of every line in one private, direct-mapped cache that sits on a shared snooping bus. Each line is in one of five states: Invalid, Shared, Exclusive, Owned or Modified. The local processor issues single-word reads and writes. The controller answers a hit at once. When it needs the bus, it raises a request and performs one transaction in each granted cycle. In parallel it watches transactions from other caches, reports whether it holds a copy, hands over the data when its copy is the responsible one, and moves the line to its new state.

The cache has a small number of lines. Each line holds a tag, a state and one data word. When a miss displaces a dirty line (Modified or Owned), the controller first writes that line back and then asks for the refill. It keeps its bus request raised across both phases, so no other cache's transaction can land between them. An arbiter outside the block supplies the grant. It is assumed never to present a snooped transaction in a cycle where this cache holds the grant.

Top module: `moesi_line_ctrl`

## Requirements
- R1: After synchronous active-low reset every line is Invalid: no snoop reports a hit, `bus_req` and `cpu_done` are low, and the first access to any address misses.
- R2: A read miss issues bus command 1 (read). The line fills with `bus_fill_data` as Exclusive when `bus_shared_in` is low at the grant, and as Shared when it is high.
- R3: A read hit in any valid state, and a write hit to an Exclusive or Modified line, complete without raising `bus_req`. A write leaves the line Modified.
- R4: A write hit to a Shared or Owned line raises `bus_req` with command 3 (invalidate). It completes only in the cycle the grant is seen, and the line becomes Modified with the written word.
- R5: A write miss to a clean or empty slot issues command 2 (read-exclusive), and the line becomes Modified holding the written word.
- R6: A snooped read (command 1) that hits a Modified line supplies the line's word and moves it to Owned. An Owned line supplies again and stays Owned. An Exclusive line moves to Shared without supplying.
- R7: A snooped read-exclusive (2) or invalidate (3) that hits moves the line to Invalid. It supplies the word in the same cycle when the line was Modified or Owned.
- R8: A miss whose slot holds a Modified or Owned line of another tag first issues command 4 (write-back) with the victim's address (old tag over index) and word. It then issues the refill command, and `bus_req` stays high from the write-back through the refill.
- R9: `snp_hit` and `snp_supply` respond in the same cycle as `snp_valid`. `snp_hit` is high for any valid, tag-matching line. `snp_data` carries the word when supplying and zero otherwise.
- R10: When a snoop targets the index of a pending local access in the same cycle, the snoop takes effect first. The local access is decided again in the next cycle from the new line state; for example, a write to an Exclusive line that is invalidated meanwhile becomes a read-exclusive miss.
- R11: `cpu_done` is a one-cycle pulse in the cycle after completion. Alongside it, `cpu_rdata` gives the line's word after the operation: the stored word for a read hit, the fill word for a read miss, and the written word for a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req | input | 1 | One-cycle request pulse, accepted when idle |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address (tag over index) |
| cpu_wdata | input | DATA_W | Write word |
| cpu_done | output | 1 | Completion pulse |
| cpu_rdata | output | DATA_W | Line word after the operation |
| bus_req | output | 1 | Bus request, held across all phases of a miss |
| bus_cmd | output | 3 | 1 read, 2 read-exclusive, 3 invalidate, 4 write-back |
| bus_addr | output | ADDR_W | Transaction address |
| bus_wdata | output | DATA_W | Write-back word |
| bus_gnt | input | 1 | Grant; the transaction happens in a cycle with grant and request high |
| bus_shared_in | input | 1 | Another cache holds the line (sampled with a read grant) |
| bus_fill_data | input | DATA_W | Fill word (sampled with a read or read-exclusive grant) |
| snp_valid | input | 1 | A snooped transaction is present |
| snp_cmd | input | 3 | 1 read, 2 read-exclusive, 3 invalidate |
| snp_addr | input | ADDR_W | Snooped address |
| snp_hit | output | 1 | This cache holds a valid copy |
| snp_supply | output | 1 | This cache drives the data |
| snp_data | output | DATA_W | Supplied word, zero otherwise |

## Verification
A local access and a snoop can target the same line in the same cycle. The bench provokes this by raising an invalidating snoop on the index of a pending write in the cycle the controller decides it. It then checks that the snoop answer reflects the state from before the write, and that the write reappears as a read-exclusive that completes with the written word. A write-back followed by a refill is the other case where two actions meet. There the bench checks, on every cycle, that the request never drops between the two phases.

// File: rtl/moesi_pkg.sv
// Shared types for the coherence controller.
// Assumes: line states fit in 3 bits; bus and snoop commands share one encoding.
package moesi_pkg;
    typedef enum logic [2:0] {
        LN_I = 3'd0,
        LN_S = 3'd1,
        LN_E = 3'd2,
        LN_O = 3'd3,
        LN_M = 3'd4
    } line_st_e;

    localparam logic [2:0] CMD_NONE = 3'd0;
    localparam logic [2:0] CMD_RD   = 3'd1;
    localparam logic [2:0] CMD_RDX  = 3'd2;
    localparam logic [2:0] CMD_INV  = 3'd3;
    localparam logic [2:0] CMD_WB   = 3'd4;
endpackage

// File: rtl/moesi_req_decode.sv
// Decides which bus transaction, if any, a local access needs right now.
// Assumes: called every cycle with the current line state, so a snoop that
// changes the line is picked up on the next evaluation.
module moesi_req_decode
    import moesi_pkg::*;
(
    input  logic     req_we,
    input  logic     line_hit,
    input  line_st_e line_st,
    output logic     need_bus,
    output logic [2:0] cmd
);
    // Select the next transaction from hit, direction and line state.
    always_comb begin
        cmd = CMD_NONE;
        if (line_hit) begin
            if (req_we && (line_st == LN_S || line_st == LN_O))
                cmd = CMD_INV;
        end else if (line_st == LN_M || line_st == LN_O) begin
            cmd = CMD_WB;
        end else begin
            cmd = req_we ? CMD_RDX : CMD_RD;
        end
        need_bus = (cmd != CMD_NONE);
    end
endmodule

// File: rtl/moesi_snoop_unit.sv
// Reaction of one line to a snooped transaction from another cache.
// Assumes: commands other than read, read-exclusive and invalidate are ignored.
module moesi_snoop_unit
    import moesi_pkg::*;
(
    input  logic       snp_valid,
    input  logic [2:0] snp_cmd,
    input  logic       tag_match,
    input  line_st_e   line_st,
    output logic       act,
    output logic       hit,
    output logic       supply,
    output line_st_e   nxt_st
);
    // Compute response and successor state for the addressed line.
    always_comb begin
        act    = snp_valid && (snp_cmd == CMD_RD || snp_cmd == CMD_RDX || snp_cmd == CMD_INV);
        hit    = act && tag_match && (line_st != LN_I);
        supply = hit && (line_st == LN_M || line_st == LN_O);
        nxt_st = line_st;
        if (snp_cmd == CMD_RD) begin
            if (line_st == LN_M) nxt_st = LN_O;
            else if (line_st == LN_E) nxt_st = LN_S;
        end else begin
            nxt_st = LN_I;
        end
    end
endmodule

// File: rtl/moesi_line_ctrl.sv
// Coherence controller for a direct-mapped private cache on a snooping bus.
// Holds tag, state and one word per line; serves one local access at a time
// and answers snoops combinationally in the same cycle.
// Assumes: the arbiter never presents a snoop while granting this cache,
// and the grant makes the requested transaction take effect in that cycle.
module moesi_line_ctrl
    import moesi_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    parameter int LINES  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_done,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              bus_req,
    output logic [2:0]        bus_cmd,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_gnt,
    input  logic              bus_shared_in,
    input  logic [DATA_W-1:0] bus_fill_data,
    input  logic              snp_valid,
    input  logic [2:0]        snp_cmd,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              snp_hit,
    output logic              snp_supply,
    output logic [DATA_W-1:0] snp_data
);
    localparam int IDX_W = $clog2(LINES);
    localparam int TAG_W = ADDR_W - IDX_W;

    line_st_e          st_q  [LINES];
    logic [TAG_W-1:0]  tag_q [LINES];
    logic [DATA_W-1:0] dat_q [LINES];

    logic              look_q, r_we, done_q;
    logic [ADDR_W-1:0] r_addr;
    logic [DATA_W-1:0] r_wdata, rdata_q, res_word;

    logic [IDX_W-1:0]  ridx, sidx;
    logic [TAG_W-1:0]  rtag, stag;
    logic              rhit, need_bus, fire, conflict, loc_ok, complete;
    logic [2:0]        dcmd;
    logic              s_act, s_hit, s_sup;
    line_st_e          s_nxt;

    assign ridx = r_addr[IDX_W-1:0];
    assign rtag = r_addr[ADDR_W-1:IDX_W];
    assign sidx = snp_addr[IDX_W-1:0];
    assign stag = snp_addr[ADDR_W-1:IDX_W];
    assign rhit = (st_q[ridx] != LN_I) && (tag_q[ridx] == rtag);

    moesi_req_decode u_dec (
        .req_we   (r_we),
        .line_hit (rhit),
        .line_st  (st_q[ridx]),
        .need_bus (need_bus),
        .cmd      (dcmd)
    );

    moesi_snoop_unit u_snp (
        .snp_valid (snp_valid),
        .snp_cmd   (snp_cmd),
        .tag_match (tag_q[sidx] == stag),
        .line_st   (st_q[sidx]),
        .act       (s_act),
        .hit       (s_hit),
        .supply    (s_sup),
        .nxt_st    (s_nxt)
    );

    // Drive the bus and snoop-response ports and the completion condition.
    always_comb begin
        bus_req    = look_q && need_bus;
        bus_cmd    = bus_req ? dcmd : CMD_NONE;
        bus_addr   = (dcmd == CMD_WB) ? {tag_q[ridx], ridx} : r_addr;
        bus_wdata  = (bus_req && dcmd == CMD_WB) ? dat_q[ridx] : '0;
        fire       = bus_req && bus_gnt;
        conflict   = s_act && (sidx == ridx);
        loc_ok     = look_q && !need_bus && !conflict;
        complete   = loc_ok || (fire && dcmd != CMD_WB);
        snp_hit    = s_hit;
        snp_supply = s_sup;
        snp_data   = s_sup ? dat_q[sidx] : '0;
        res_word   = r_we ? r_wdata : (fire ? bus_fill_data : dat_q[ridx]);
    end

    // Accept one local access, hold it until it completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            look_q  <= 1'b0;
            r_we    <= 1'b0;
            r_addr  <= '0;
            r_wdata <= '0;
        end else if (!look_q && cpu_req) begin
            look_q  <= 1'b1;
            r_we    <= cpu_we;
            r_addr  <= cpu_addr;
            r_wdata <= cpu_wdata;
        end else if (complete) begin
            look_q  <= 1'b0;
        end
    end

    // Register the completion pulse and the resulting word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q  <= 1'b0;
            rdata_q <= '0;
        end else begin
            done_q  <= complete;
            if (complete) rdata_q <= res_word;
        end
    end

    assign cpu_done  = done_q;
    assign cpu_rdata = rdata_q;

    // Update line tag, state and word from snoops first, then local actions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < LINES; i++) begin
                st_q[i]  <= LN_I;
                tag_q[i] <= '0;
                dat_q[i] <= '0;
            end
        end else begin
            if (s_hit) st_q[sidx] <= s_nxt;
            if (loc_ok && r_we) begin
                st_q[ridx]  <= LN_M;
                dat_q[ridx] <= r_wdata;
            end
            if (fire) begin
                case (dcmd)
                    CMD_INV: begin
                        st_q[ridx]  <= LN_M;
                        dat_q[ridx] <= r_wdata;
                    end
                    CMD_WB:  st_q[ridx] <= LN_I;
                    CMD_RD: begin
                        st_q[ridx]  <= bus_shared_in ? LN_S : LN_E;
                        tag_q[ridx] <= rtag;
                        dat_q[ridx] <= bus_fill_data;
                    end
                    CMD_RDX: begin
                        st_q[ridx]  <= LN_M;
                        tag_q[ridx] <= rtag;
                        dat_q[ridx] <= r_wdata;
                    end
                    default: ;
                endcase
            end
        end
    end

    // R8: after a write-back the request stays up for the refill
    wb_then_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && bus_cmd == CMD_WB) |=> (bus_req && (bus_cmd == CMD_RD || bus_cmd == CMD_RDX)));

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done |=> !cpu_done);

    // R3
    write_leaves_m_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_done && r_we) |-> (st_q[ridx] == LN_M));

    // R7
    snoop_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_hit && snp_cmd != CMD_RD) |=> (st_q[$past(sidx)] == LN_I));

    // R6
    m_to_owned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_hit && snp_cmd == CMD_RD && snp_supply) |=> (st_q[$past(sidx)] == LN_O));

    // R10: snoops and own grants never share a cycle
    snoop_vs_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(snp_valid && bus_gnt));
endmodule

// File: tb/moesi_line_ctrl_bench.sv
// Self-checking bench with a behavioural line-state model kept in arrays.
module moesi_line_ctrl_bench;
    localparam int ST_I = 0, ST_S = 1, ST_E = 2, ST_O = 3, ST_M = 4;
    localparam int C_RD = 1, C_RDX = 2, C_INV = 3, C_WB = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [7:0]  cpu_addr = '0;
    logic [15:0] cpu_wdata = '0;
    logic        cpu_done;
    logic [15:0] cpu_rdata;
    logic        bus_req;
    logic [2:0]  bus_cmd;
    logic [7:0]  bus_addr;
    logic [15:0] bus_wdata;
    logic        bus_gnt = 1'b0, bus_shared_in = 1'b0;
    logic [15:0] bus_fill_data = '0;
    logic        snp_valid = 1'b0;
    logic [2:0]  snp_cmd = '0;
    logic [7:0]  snp_addr = '0;
    logic        snp_hit, snp_supply;
    logic [15:0] snp_data;

    int checks = 0, errors = 0;
    bit idle_phase = 1'b0;
    bit finished = 1'b0;

    int          m_st  [8];
    logic [4:0]  m_tag [8];
    logic [15:0] m_dat [8];

    always #5 clk = ~clk;

    moesi_line_ctrl u_moesi_line_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
        .bus_req(bus_req), .bus_cmd(bus_cmd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_gnt(bus_gnt), .bus_shared_in(bus_shared_in), .bus_fill_data(bus_fill_data),
        .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
        .snp_hit(snp_hit), .snp_supply(snp_supply), .snp_data(snp_data)
    );

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s act=%0h exp=%0h", rq, what, act, exp);
        end
    endtask

    // Per-clock comparison: outside an access the model expects a quiet bus.
    always @(negedge clk) begin
        if (rst_n && idle_phase) begin
            chk(bus_req == 1'b0, "R3", "idle bus_req", 32'(bus_req), 0);
            chk(cpu_done == 1'b0, "R11", "idle cpu_done", 32'(cpu_done), 0);
        end
    end

    // Snoop one transaction and compare against the model.
    task automatic snoop(input int cmd, input logic [7:0] addr, input string rq);
        int idx = int'(addr[2:0]);
        bit hit = (m_st[idx] != ST_I) && (m_tag[idx] == addr[7:3]);
        bit sup = hit && (m_st[idx] == ST_M || m_st[idx] == ST_O);
        logic [15:0] ed = sup ? m_dat[idx] : 16'h0;
        @(negedge clk);
        snp_valid = 1'b1; snp_cmd = 3'(cmd); snp_addr = addr;
        #1;
        chk(snp_hit == hit, rq, "snp_hit", 32'(snp_hit), 32'(hit));
        chk(snp_supply == sup, rq, "snp_supply", 32'(snp_supply), 32'(sup));
        chk(snp_data == ed, rq, "snp_data", 32'(snp_data), 32'(ed));
        if (hit) begin
            if (cmd == C_RD) begin
                if (m_st[idx] == ST_M) m_st[idx] = ST_O;
                else if (m_st[idx] == ST_E) m_st[idx] = ST_S;
            end else m_st[idx] = ST_I;
        end
        @(negedge clk);
        snp_valid = 1'b0;
    endtask

    // One local access; optional invalidating snoop in the decision cycle.
    task automatic cpu_op(input bit we, input logic [7:0] addr, input logic [15:0] wd,
                          input bit shr, input logic [15:0] fill, input int gdly,
                          input bit collide, input string rq);
        int idx = int'(addr[2:0]);
        int exp_cmd [2];
        int n_exp = 0, ncmd = 0, w = 0;
        bit hit, newph = 1'b1;
        logic [7:0]  vaddr;
        logic [15:0] vdat, erd;
        idle_phase = 1'b0;
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = addr; cpu_wdata = wd;
        @(negedge clk);
        cpu_req = 1'b0;
        if (collide) begin
            snp_valid = 1'b1; snp_cmd = 3'(C_INV); snp_addr = addr;
            #1;
            chk(snp_hit == 1'b1, "R10", "collide snp_hit", 32'(snp_hit), 1);
            chk(snp_supply == 1'b0, "R10", "collide supply", 32'(snp_supply), 0);
            m_st[idx] = ST_I;
            @(negedge clk);
            snp_valid = 1'b0;
        end
        hit = (m_st[idx] != ST_I) && (m_tag[idx] == addr[7:3]);
        vaddr = {m_tag[idx], addr[2:0]};
        vdat  = m_dat[idx];
        if (hit) begin
            if (we && (m_st[idx] == ST_S || m_st[idx] == ST_O)) begin
                exp_cmd[0] = C_INV; n_exp = 1;
            end
        end else begin
            if (m_st[idx] == ST_M || m_st[idx] == ST_O) begin
                exp_cmd[n_exp] = C_WB; n_exp++;
            end
            exp_cmd[n_exp] = we ? C_RDX : C_RD; n_exp++;
        end
        erd = we ? wd : (hit ? m_dat[idx] : fill);
        for (int c = 0; c < 60; c++) begin
            if (bus_gnt) begin bus_gnt = 1'b0; newph = 1'b1; end
            if (cpu_done) break;
            if (bus_req) begin
                if (newph) begin
                    if (ncmd < n_exp) begin
                        chk(bus_cmd == 3'(exp_cmd[ncmd]), rq, "bus_cmd", 32'(bus_cmd), 32'(exp_cmd[ncmd]));
                        if (exp_cmd[ncmd] == C_WB) begin
                            chk(bus_addr == vaddr, "R8", "wb addr", 32'(bus_addr), 32'(vaddr));
                            chk(bus_wdata == vdat, "R8", "wb data", 32'(bus_wdata), 32'(vdat));
                        end else begin
                            chk(bus_addr == addr, rq, "bus_addr", 32'(bus_addr), 32'(addr));
                        end
                    end else begin
                        chk(1'b0, rq, "extra bus cmd", 32'(bus_cmd), 0);
                    end
                    ncmd++; newph = 1'b0; w = 0;
                end
                if (w >= gdly) begin
                    bus_gnt = 1'b1; bus_shared_in = shr; bus_fill_data = fill;
                end
                w++;
            end else if (ncmd > 0) begin
                chk(1'b0, "R8", "bus_req dropped mid-miss", 0, 1);
            end
            @(negedge clk);
        end
        bus_gnt = 1'b0;
        chk(cpu_done == 1'b1, "R11", "cpu_done", 32'(cpu_done), 1);
        chk(ncmd == n_exp, rq, "bus cmd count", 32'(ncmd), 32'(n_exp));
        chk(cpu_rdata == erd, rq, "cpu_rdata", 32'(cpu_rdata), 32'(erd));
        m_tag[idx] = addr[7:3];
        if (we) begin
            m_st[idx] = ST_M; m_dat[idx] = wd;
        end else if (!hit) begin
            m_st[idx] = shr ? ST_S : ST_E; m_dat[idx] = fill;
        end
        @(negedge clk);
        chk(cpu_done == 1'b0, "R11", "done is one pulse", 32'(cpu_done), 0);
        idle_phase = 1'b1;
    endtask

    initial begin
        for (int i = 0; i < 8; i++) begin m_st[i] = ST_I; m_tag[i] = '0; m_dat[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(bus_req == 1'b0, "R1", "reset bus_req", 32'(bus_req), 0);
        chk(cpu_done == 1'b0, "R1", "reset cpu_done", 32'(cpu_done), 0);
        for (int i = 0; i < 8; i++) snoop(C_RD, 8'(i), "R1");
        idle_phase = 1'b1;
        // R2 exclusive fill, R9/R6 E->S, R4 invalidate with late grant
        cpu_op(0, 8'h11, 16'h0, 0, 16'hA1A1, 0, 0, "R2");
        snoop(C_RD, 8'h11, "R6");
        cpu_op(1, 8'h11, 16'hB1B1, 0, 16'h0, 2, 0, "R4");
        // R6 Modified -> Owned supplies, Owned supplies again
        snoop(C_RD, 8'h11, "R6");
        snoop(C_RD, 8'h11, "R9");
        cpu_op(1, 8'h11, 16'hC1C1, 0, 16'h0, 1, 0, "R4");
        // R2 shared fill then invalidate
        cpu_op(0, 8'h22, 16'h0, 1, 16'hA2A2, 0, 0, "R2");
        cpu_op(0, 8'h22, 16'h0, 0, 16'h0, 0, 0, "R3");
        cpu_op(1, 8'h22, 16'hB2B2, 0, 16'h0, 0, 0, "R4");
        // R3 write hit on Exclusive without bus
        cpu_op(0, 8'h33, 16'h0, 0, 16'hA3A3, 0, 0, "R2");
        cpu_op(1, 8'h33, 16'hB3B3, 0, 16'h0, 0, 0, "R3");
        cpu_op(1, 8'h33, 16'hB4B4, 0, 16'h0, 0, 0, "R3");
        // R8 evict Modified
        cpu_op(0, 8'h43, 16'h0, 0, 16'hA4A4, 1, 0, "R8");
        // R7 read-exclusive snoop on Modified
        snoop(C_RDX, 8'h11, "R7");
        snoop(C_RD, 8'h11, "R7");
        // R5 write miss, then invalidate snoop supplies
        cpu_op(1, 8'h54, 16'hB5B5, 0, 16'hFFFF, 0, 0, "R5");
        snoop(C_INV, 8'h54, "R7");
        snoop(C_INV, 8'h54, "R7");
        // R10 same-cycle collision on an Exclusive line
        cpu_op(1, 8'h43, 16'hB6B6, 0, 16'h1234, 1, 1, "R10");
        // R8 evict Owned
        cpu_op(1, 8'h66, 16'hB7B7, 0, 16'h0, 0, 0, "R5");
        snoop(C_RD, 8'h66, "R6");
        cpu_op(0, 8'h0E, 16'h0, 1, 16'hA8A8, 0, 0, "R8");
        // R8 evict Modified on a write miss
        cpu_op(1, 8'h83, 16'hB9B9, 0, 16'h0, 0, 0, "R8");
        // R9 miss on tag mismatch
        snoop(C_RD, 8'h4B, "R9");
        idle_phase = 1'b0;
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #2000000;
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog act=0 exp=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule